// File: doc/BRIEF.md
# Select-Indexed Priority Interrupt Controller

This block is a vectored interrupt controller for up to 128 request lines on a 32-bit register bus. The per-source settings are not mapped one register per source. Software first writes a source number into a select register. The mode, vector and one-bit command registers then act on that one source only. Each source has a 3-bit priority, a trigger type, a 32-bit vector, an enable bit and a latched request.

An arbiter picks the highest-priority pending, enabled source. It raises the active-low interrupt output only when that source outranks the level currently being serviced. Reading the interrupt-vector register returns the winner's vector and acknowledges it: the winner's priority and number are pushed onto an eight-entry nesting stack, and only end-of-interrupt writes pop that stack. When nothing can be taken, the vector read returns a programmable spurious value and changes nothing.

Top module: `sel_prio_intc`

## Requirements
- R1: After reset all sources are disabled, have no latched request and have mode 0. The stack is empty, `irq_no` is 1, and the select, spurious, mask (0x30), vector-read (0x10) and current-source (0x18) registers all read 0.
- R2: The select register (0x00) keeps the low 7 bits of a write and reads them back. The mode (0x04) and vector (0x08) registers read and write the stored settings of the selected source only.
- R3: Writing a word with bit 0 set to the enable command (0x40) or disable command (0x44) sets or clears the mask bit of the selected source only, and a word with bit 0 clear has no effect. Register 0x30 returns the selected mask bit in bit 0. A disabled source never pulls `irq_no` low.
- R4: Writing bit 0 = 1 to the set command (0x4C) latches a request for the selected source. Writing bit 0 = 1 to the clear command (0x48) drops its latched request.
- R5: The mode word holds the priority in bits [2:0] and the trigger type in bits [6:5]: 00 low level, 01 falling edge, 10 high level, 11 rising edge. Other bits are ignored. A level source is pending while its input is at the active level, even after a clear command. An edge source latches its request within three clock cycles of the edge.
- R6: Among pending, enabled sources the highest priority wins, and a tie goes to the lower source number. `irq_no` goes low only when the stack is empty or the winner's priority is strictly above the priority on top of the stack.
- R7: A read of 0x10 while `irq_no` is low returns the winner's vector. It pushes the winner onto the stack, drops its latched request, and makes 0x18 read the winner's number until the matching end-of-interrupt.
- R8: A read of 0x10 while `irq_no` is high returns the spurious-vector register (0x3C, read/write) and leaves the stack unchanged. Register 0x18 reads 0 while the stack is empty.
- R9: Each write to 0x38 pops one stack entry. The write is accepted and ignored when the stack is empty, so eight such writes always empty the stack.
- R10: The stack nests up to eight levels, one for each priority, and never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Interrupt request inputs, one per source |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_no | output | 1 | Interrupt request to the processor, active low |

## Verification
The hardest state to reach is a completely full nesting stack. It takes eight sources with distinct priorities, acknowledged in rising order, with a further equal-priority request left waiting so that the top-of-stack comparison is exercised at its edge. The bench builds this with a directed sequence, then masks the waiting source and checks that exactly eight end-of-interrupt writes release the output. A seeded random phase then mixes configuration, set, clear, acknowledge and end-of-interrupt operations on a small group of sources, so that equal priorities and nested acknowledges come up often. Each result is compared against a model of mask bits, latches and the stack kept in the bench.

// File: rtl/sel_prio_intc_pkg.sv
package sel_prio_intc_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned NEST_DEPTH = 1 << PRIO_W;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SEL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_IVEC = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CUR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_EOI  = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_SPU  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_DIS  = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_SET  = 8'h4C;

  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'b00,
    TRIG_FALL     = 2'b01,
    TRIG_HIGH_LVL = 2'b10,
    TRIG_RISE     = 2'b11
  } trig_e;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import sel_prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned VEC_W   = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SRC-1:0]              src_i,
  input  logic [IDX_W-1:0]                sel_i,
  input  logic                            mode_we_i,
  input  logic [PRIO_W-1:0]               mode_prio_i,
  input  trig_e                           mode_trig_i,
  input  logic                            vec_we_i,
  input  logic [VEC_W-1:0]                vec_wdata_i,
  input  logic                            en_cmd_i,
  input  logic                            dis_cmd_i,
  input  logic                            clr_cmd_i,
  input  logic                            set_cmd_i,
  input  logic                            ack_i,
  input  logic [IDX_W-1:0]                ack_idx_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC-1:0]              elig_o,
  output logic [PRIO_W-1:0]               sel_prio_o,
  output trig_e                           sel_trig_o,
  output logic [VEC_W-1:0]                sel_vec_o,
  output logic                            sel_en_o,
  output logic [VEC_W-1:0]                ack_vec_o
);
  logic [NUM_SRC-1:0][VEC_W-1:0] vec_all;
  logic [NUM_SRC-1:0][1:0]       trig_all;
  logic [NUM_SRC-1:0]            en_all;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_q;
    trig_e             trig_q;
    logic [VEC_W-1:0]  vec_q;
    logic              en_q, latch_q, s1_q, s2_q;
    logic              hit, edge_hit, lvl_hit, drop, raise;

    assign hit      = (sel_i == IDX_W'(g));
    assign lvl_hit  = ((trig_q == TRIG_HIGH_LVL) &&  s1_q) ||
                      ((trig_q == TRIG_LOW_LVL)  && !s1_q);
    assign edge_hit = ((trig_q == TRIG_RISE) &&  s1_q && !s2_q) ||
                      ((trig_q == TRIG_FALL) && !s1_q &&  s2_q);
    assign drop     = (hit && clr_cmd_i) || (ack_i && ack_idx_i == IDX_W'(g));
    assign raise    = (hit && set_cmd_i) || edge_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q  <= '0;
        trig_q  <= TRIG_LOW_LVL;
        vec_q   <= '0;
        en_q    <= 1'b0;
        latch_q <= 1'b0;
        s1_q    <= 1'b0;
        s2_q    <= 1'b0;
      end else begin
        s1_q <= src_i[g];
        s2_q <= s1_q;
        if (hit && mode_we_i) begin
          prio_q <= mode_prio_i;
          trig_q <= mode_trig_i;
        end
        if (hit && vec_we_i) vec_q <= vec_wdata_i;
        if (hit && en_cmd_i)       en_q <= 1'b1;
        else if (hit && dis_cmd_i) en_q <= 1'b0;
        // a fresh edge in the acknowledge cycle is kept
        latch_q <= (latch_q && !drop) || raise;
      end
    end

    assign prio_o[g]   = prio_q;
    assign elig_o[g]   = en_q && (latch_q || lvl_hit);
    assign vec_all[g]  = vec_q;
    assign trig_all[g] = trig_q;
    assign en_all[g]   = en_q;
  end

  assign sel_prio_o = prio_o[sel_i];
  assign sel_trig_o = trig_e'(trig_all[sel_i]);
  assign sel_vec_o  = vec_all[sel_i];
  assign sel_en_o   = en_all[sel_i];
  assign ack_vec_o  = vec_all[ack_idx_i];
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import sel_prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             elig_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               win_idx_o,
  output logic [PRIO_W-1:0]              win_prio_o
);
  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!found_o || prio_i[i] > win_prio_o)) begin
        found_o    = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/intc_nest_stack.sv
module intc_nest_stack
  import sel_prio_intc_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DEPTH  = NEST_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [IDX_W-1:0]  top_idx_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
  logic [DEPTH-1:0][IDX_W-1:0]  idx_q;
  logic [LVL_W-1:0]             lvl_q;
  logic [PTR_W-1:0]             wr_ptr, top_ptr;

  assign wr_ptr  = PTR_W'(lvl_q);
  assign top_ptr = PTR_W'(lvl_q - LVL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      idx_q  <= '0;
      lvl_q  <= '0;
    end else if (push_i && lvl_q < LVL_W'(DEPTH)) begin
      prio_q[wr_ptr] <= push_prio_i;
      idx_q[wr_ptr]  <= push_idx_i;
      lvl_q          <= lvl_q + LVL_W'(1);
    end else if (pop_i && lvl_q != '0) begin
      lvl_q <= lvl_q - LVL_W'(1);
    end
  end

  assign empty_o    = (lvl_q == '0);
  assign top_prio_o = empty_o ? '0 : prio_q[top_ptr];
  assign top_idx_o  = empty_o ? '0 : idx_q[top_ptr];
  assign level_o    = lvl_q;

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> lvl_q < LVL_W'(DEPTH));
  a_r6_push_above_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && lvl_q != '0) |-> push_prio_i > prio_q[top_ptr]);
endmodule

// File: rtl/sel_prio_intc.sv
module sel_prio_intc
  import sel_prio_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned LVL_W  = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_no
);
  logic                            wr, rd, cmd_bit;
  logic [IDX_W-1:0]                sel_q;
  logic [DATA_W-1:0]               spu_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_all;
  logic [NUM_SRC-1:0]              elig;
  logic [PRIO_W-1:0]               sel_prio, win_prio, top_prio;
  trig_e                           sel_trig;
  logic [DATA_W-1:0]               sel_vec, win_vec;
  logic                            sel_en, found, empty, irq_valid, ack, eoi;
  logic [IDX_W-1:0]                win_idx, top_idx;
  logic [LVL_W-1:0]                level;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign cmd_bit = wr && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      spu_q <= '0;
    end else if (wr) begin
      if (addr_i == OFF_SEL) sel_q <= wdata_i[IDX_W-1:0];
      if (addr_i == OFF_SPU) spu_q <= wdata_i;
    end
  end

  intc_src_bank #(.NUM_SRC(NUM_SRC), .VEC_W(DATA_W)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .sel_i       (sel_q),
    .mode_we_i   (wr && addr_i == OFF_MODE),
    .mode_prio_i (wdata_i[PRIO_W-1:0]),
    .mode_trig_i (trig_e'(wdata_i[6:5])),
    .vec_we_i    (wr && addr_i == OFF_VEC),
    .vec_wdata_i (wdata_i),
    .en_cmd_i    (cmd_bit && addr_i == OFF_EN),
    .dis_cmd_i   (cmd_bit && addr_i == OFF_DIS),
    .clr_cmd_i   (cmd_bit && addr_i == OFF_CLR),
    .set_cmd_i   (cmd_bit && addr_i == OFF_SET),
    .ack_i       (ack),
    .ack_idx_i   (win_idx),
    .prio_o      (prio_all),
    .elig_o      (elig),
    .sel_prio_o  (sel_prio),
    .sel_trig_o  (sel_trig),
    .sel_vec_o   (sel_vec),
    .sel_en_o    (sel_en),
    .ack_vec_o   (win_vec)
  );

  intc_prio_arb #(.NUM_SRC(NUM_SRC)) i_arb (
    .elig_i     (elig),
    .prio_i     (prio_all),
    .found_o    (found),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  intc_nest_stack #(.IDX_W(IDX_W), .DEPTH(NEST_DEPTH)) i_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack),
    .push_prio_i (win_prio),
    .push_idx_i  (win_idx),
    .pop_i       (eoi),
    .empty_o     (empty),
    .top_prio_o  (top_prio),
    .top_idx_o   (top_idx),
    .level_o     (level)
  );

  assign irq_valid = found && (empty || win_prio > top_prio);
  assign irq_no    = !irq_valid;
  assign ack       = rd && addr_i == OFF_IVEC && irq_valid;
  assign eoi       = wr && addr_i == OFF_EOI;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_SEL:  rdata_o[IDX_W-1:0] = sel_q;
      OFF_MODE: begin
        rdata_o[PRIO_W-1:0] = sel_prio;
        rdata_o[6:5]        = sel_trig;
      end
      OFF_VEC:  rdata_o = sel_vec;
      OFF_IVEC: rdata_o = irq_valid ? win_vec : spu_q;
      OFF_CUR:  rdata_o[IDX_W-1:0] = top_idx;
      OFF_MASK: rdata_o[0] = sel_en;
      OFF_SPU:  rdata_o = spu_q;
      default:  rdata_o = '0;
    endcase
  end

  a_r7_ack_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> level == $past(level) + LVL_W'(1));
  a_r8_spurious_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFF_IVEC && irq_no) |=> level == $past(level));
  a_r9_eoi_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && level != '0) |=> level == $past(level) - LVL_W'(1));
  a_r9_eoi_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && level == '0) |=> level == '0);
  a_r3_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> elig[win_idx]);
endmodule

// File: tb/test_sel_prio_intc.sv
module test_sel_prio_intc;
  localparam int NSRC = 128;
  localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08, A_IVEC = 8'h10,
                         A_CUR = 8'h18, A_MASK = 8'h30, A_EOI = 8'h38, A_SPU = 8'h3C,
                         A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48, A_SET = 8'h4C;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NSRC-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0;

  sel_prio_intc #(.NUM_SRC(NSRC)) i_sel_prio_intc (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  // bench model
  bit [2:0]  m_prio[NSRC];
  bit [31:0] m_vec[NSRC];
  bit        m_en[NSRC];
  bit        m_lat[NSRC];
  bit [2:0]  st_prio[8];
  int        st_idx[8];
  int        m_sp;
  bit [31:0] m_spu;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1; d = rdata;
    @(posedge clk); #1; req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    check(tag, {31'b0, irq_n}, {31'b0, exp});
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src[i] = v;
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src = '0;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      m_prio[i] = '0; m_vec[i] = '0; m_en[i] = 1'b0; m_lat[i] = 1'b0;
    end
    m_sp = 0; m_spu = '0;
  endtask

  task automatic cfg(input int i, input logic [31:0] mode, input logic [31:0] vec);
    wr(A_SEL, i); wr(A_MODE, mode); wr(A_VEC, vec);
  endtask

  function automatic int exp_win();
    int best = -1;
    for (int i = 0; i < NSRC; i++)
      if (m_en[i] && m_lat[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
    if (best >= 0 && m_sp > 0 && m_prio[best] <= st_prio[m_sp-1]) best = -1;
    return best;
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    irq_chk("R1 irq_no", 1'b1);
    rd_chk("R1 select", A_SEL, 32'h0);
    rd_chk("R1 mask", A_MASK, 32'h0);
    rd_chk("R1 mode", A_MODE, 32'h0);
    rd_chk("R1 spurious", A_SPU, 32'h0);
    rd_chk("R1 vector read", A_IVEC, 32'h0);
    rd_chk("R1 current", A_CUR, 32'h0);

    // R2 selection and per-source storage
    wr(A_SEL, 32'h185);
    rd_chk("R2 select low bits", A_SEL, 32'h05);
    wr(A_MODE, 32'h63); wr(A_VEC, 32'hABCD_0005);
    wr(A_SEL, 6); wr(A_VEC, 32'h1111_0006);
    rd_chk("R2 vector src6", A_VEC, 32'h1111_0006);
    rd_chk("R2 mode src6 untouched", A_MODE, 32'h0);
    wr(A_SEL, 5);
    rd_chk("R2 vector src5", A_VEC, 32'hABCD_0005);
    rd_chk("R2 mode src5", A_MODE, 32'h63);
    wr(A_MODE, 32'hFFFF_FF9B);
    rd_chk("R5 mode field mask", A_MODE, 32'h03);

    // R3 enable / disable commands
    wr(A_MODE, 32'h63);
    wr(A_EN, 32'h0);
    rd_chk("R3 enable bit0 clear ignored", A_MASK, 32'h0);
    wr(A_EN, 32'h1);
    rd_chk("R3 enable", A_MASK, 32'h1);
    wr(A_SEL, 6);
    rd_chk("R3 other source unmasked", A_MASK, 32'h0);
    wr(A_SEL, 5);
    wr(A_DIS, 32'h2);
    rd_chk("R3 disable bit0 clear ignored", A_MASK, 32'h1);
    wr(A_DIS, 32'h1);
    rd_chk("R3 disable", A_MASK, 32'h0);

    // R5 / R4 trigger types, set and clear
    do_reset();
    cfg(5, 32'h42, 32'h5); wr(A_EN, 1);
    irq_chk("R5 high level idle", 1'b1);
    set_src(5, 1'b1);
    irq_chk("R5 high level active", 1'b0);
    wr(A_CLR, 1);
    irq_chk("R5 level survives clear", 1'b0);
    set_src(5, 1'b0);
    irq_chk("R5 high level released", 1'b1);

    cfg(6, 32'h61, 32'h6); wr(A_EN, 1);
    set_src(6, 1'b1); set_src(6, 1'b0);
    irq_chk("R5 rising edge latched", 1'b0);
    wr(A_CLR, 1);
    irq_chk("R4 clear drops latch", 1'b1);
    wr(A_SET, 1);
    irq_chk("R4 set forces request", 1'b0);
    wr(A_CLR, 1);

    cfg(7, 32'h21, 32'h7); wr(A_EN, 1);
    set_src(7, 1'b1);
    irq_chk("R5 falling edge not on rise", 1'b1);
    set_src(7, 1'b0);
    irq_chk("R5 falling edge latched", 1'b0);
    wr(A_CLR, 1);

    @(negedge clk); src[8] = 1'b1;
    cfg(8, 32'h00, 32'h8); wr(A_EN, 1); idle(2);
    irq_chk("R5 low level idle", 1'b1);
    set_src(8, 1'b0);
    irq_chk("R5 low level active", 1'b0);
    set_src(8, 1'b1);
    irq_chk("R5 low level released", 1'b1);

    cfg(9, 32'h63, 32'h9); wr(A_SET, 1);
    irq_chk("R3 disabled source silent", 1'b1);
    wr(A_EN, 1);
    irq_chk("R3 enabled source raises", 1'b0);
    wr(A_DIS, 1);
    irq_chk("R3 disabled again", 1'b1);

    // R6 R7 R8 R9 arbitration, acknowledge, spurious, end of interrupt
    do_reset();
    wr(A_SPU, 32'hDEAD_BEEF);
    cfg(10, 32'h62, 32'hA10); wr(A_SET, 1); wr(A_EN, 1);
    cfg(11, 32'h65, 32'hA11); wr(A_SET, 1); wr(A_EN, 1);
    cfg(12, 32'h65, 32'hA12); wr(A_SET, 1); wr(A_EN, 1);
    irq_chk("R6 pending raises irq", 1'b0);
    rd_chk("R6 tie lower index wins", A_IVEC, 32'hA11);
    rd_chk("R7 current source", A_CUR, 32'd11);
    irq_chk("R6 equal priority blocked", 1'b1);
    rd_chk("R8 spurious vector", A_IVEC, 32'hDEAD_BEEF);
    rd_chk("R8 no push on spurious", A_CUR, 32'd11);
    wr(A_EOI, 0);
    rd_chk("R9 stack empty after eoi", A_CUR, 32'd0);
    irq_chk("R6 waiting source raises", 1'b0);
    rd_chk("R6 second winner", A_IVEC, 32'hA12);
    wr(A_EOI, 0);
    rd_chk("R6 lowest priority last", A_IVEC, 32'hA10);
    rd_chk("R7 current low source", A_CUR, 32'd10);
    wr(A_EOI, 0);
    irq_chk("R7 acknowledge drops latches", 1'b1);
    rd_chk("R8 spurious after drain", A_IVEC, 32'hDEAD_BEEF);
    wr(A_EOI, 0);
    rd_chk("R9 eoi on empty ignored", A_CUR, 32'd0);
    irq_chk("R9 irq stays high", 1'b1);

    // R10 full nesting
    do_reset();
    for (int k = 0; k < 8; k++) begin
      cfg(20 + k, 32'h60 | k, 32'h100 + k); wr(A_EN, 1); wr(A_SET, 1);
      rd_chk("R10 nested acknowledge", A_IVEC, 32'h100 + k);
      rd_chk("R10 nested current", A_CUR, 20 + k);
    end
    cfg(30, 32'h67, 32'h130); wr(A_EN, 1); wr(A_SET, 1);
    irq_chk("R6 full stack blocks equal priority", 1'b1);
    wr(A_DIS, 1);
    for (int k = 0; k < 7; k++) wr(A_EOI, 0);
    rd_chk("R9 bottom entry after seven eoi", A_CUR, 32'd20);
    wr(A_EOI, 0);
    rd_chk("R9 eight eoi empty the stack", A_CUR, 32'd0);
    irq_chk("R9 irq released", 1'b1);
    wr(A_EN, 1);
    rd_chk("R10 push after drain", A_IVEC, 32'h130);

    // random phase against the model
    do_reset();
    m_spu = $urandom;
    wr(A_SPU, m_spu);
    for (int it = 0; it < 600; it++) begin
      int idx, w, op;
      idx = ($urandom_range(0, 15) * 7) % NSRC;
      op  = $urandom_range(0, 5);
      case (op)
        0: begin
          logic [31:0] mode, vec;
          mode = ($urandom_range(2, 3) << 5) | $urandom_range(0, 7);
          vec  = $urandom;
          cfg(idx, mode, vec);
          m_prio[idx] = mode[2:0]; m_vec[idx] = vec;
          if ($urandom_range(0, 3) != 0) begin wr(A_EN, 1); m_en[idx] = 1'b1; end
          else begin wr(A_DIS, 1); m_en[idx] = 1'b0; end
        end
        1: begin wr(A_SEL, idx); wr(A_SET, 1); m_lat[idx] = 1'b1; end
        2: begin wr(A_SEL, idx); wr(A_CLR, 1); m_lat[idx] = 1'b0; end
        3, 4: begin
          w = exp_win();
          rd(A_IVEC, d);
          if (w >= 0) begin
            check("R7 random vector", d, m_vec[w]);
            st_prio[m_sp] = m_prio[w]; st_idx[m_sp] = w; m_sp++;
            m_lat[w] = 1'b0;
          end else begin
            check("R8 random spurious", d, m_spu);
          end
        end
        default: begin wr(A_EOI, 0); if (m_sp > 0) m_sp--; end
      endcase
      irq_chk("R6 random irq", (exp_win() < 0));
      if (it % 8 == 0)
        rd_chk("R7 random current", A_CUR, (m_sp > 0) ? st_idx[m_sp-1] : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule